// File: doc/BRIEF.md
# Raster Timing Generator

This block drives the timing side of a raster panel. Software writes a set of length settings for each axis: visible size, porch before sync, sync width and porch after sync. The block then runs free on the pixel clock. It produces horizontal sync, vertical sync and a data-enable strobe. It also produces the column and row of the pixel that is due on the current clock. A pixel source further down the chip uses that column and row to fetch or compute the colour.

Each of the three strobes has its own polarity and its own enable. An output that is disabled stays at its idle level. The strobes can be launched on either edge of the pixel clock. The data group (enable, column, row) follows one edge select. The sync group follows a second select when that select is switched on, and otherwise uses the data group's edge. A line-doubling mode sends every visible row twice, which suits sources with half the panel's vertical resolution. All settings are captured together at a frame boundary, so a frame in flight never mixes old and new values.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts active + front + sync + back pixel clocks, in that order. The line starts with its visible pixels, so the column is 0 in the first clock of every line.
- R2: A frame holds visible lines, then front-porch lines, then sync lines, then back-porch lines. The row counter moves only when a line ends.
- R3: Each polarity bit sets the asserted level of its strobe. A value of 1 makes the strobe active high, and 0 makes it active low.
- R4: When the enable of a strobe is 0, that strobe stays at its idle level, which is the inverse of its polarity bit.
- R5: A data edge select of 1 makes data enable, column and row change on the rising clock edge. A value of 0 makes them change on the falling edge, half a cycle before the rising edge where a sink samples them.
- R6: Both syncs use the data edge select unless the sync-edge override bit is 1. With the override set, they use the sync edge bit instead, with the same 1 = rising encoding.
- R7: With line doubling on, each visible row number is output on two lines in a row. The porch and sync line counts stay as written.
- R8: Data enable is asserted only where the line and the frame are both in their visible parts. Column and row read 0 at every other time.
- R9: Settings written during a frame take effect from the first clock of the next frame.
- R10: Any length written as 0 behaves as a length of 1.
- R11: While the synchronous reset is high, the counters stay at the origin (column 0, row 0 of a visible pixel) and the current settings are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_active | input | HW | Visible pixels per line |
| cfg_h_front | input | HW | Pixels between visible part and sync |
| cfg_h_sync | input | HW | Horizontal sync width in pixels |
| cfg_h_back | input | HW | Pixels between sync and next line |
| cfg_v_active | input | VW | Visible lines per frame |
| cfg_v_front | input | VW | Lines between visible part and sync |
| cfg_v_sync | input | VW | Vertical sync width in lines |
| cfg_v_back | input | VW | Lines between sync and next frame |
| cfg_hs_pol | input | 1 | Horizontal sync asserted level |
| cfg_vs_pol | input | 1 | Vertical sync asserted level |
| cfg_de_pol | input | 1 | Data enable asserted level |
| cfg_hs_en | input | 1 | Horizontal sync in use |
| cfg_vs_en | input | 1 | Vertical sync in use |
| cfg_de_en | input | 1 | Data enable in use |
| cfg_data_edge | input | 1 | Launch edge of data group, 1 = rising |
| cfg_sync_edge_own | input | 1 | Syncs take their own edge select |
| cfg_sync_edge | input | 1 | Launch edge of syncs when overridden, 1 = rising |
| cfg_dscan | input | 1 | Line doubling |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | HW | Column of the current pixel |
| px_y | output | VW | Row of the current pixel |

## Verification
The counters and the captured settings update on the rising edge. Each output then passes through one launch register before it reaches a pin. Measured just after a rising edge, every output shows the counter state from the previous rising edge, whatever the edge selects are. Measured just after a falling edge, a group launched on the falling edge already shows the state from the latest rising edge, while a group launched on the rising edge still shows the older state. The bench therefore keeps both the latest and the previous expected state of its own model. It compares the outputs against them two time units after every rising edge and every falling edge, picking the expected state by each group's edge select.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Region of one axis; the encoding order follows the scan sequence.
    typedef enum logic [1:0] {
        RG_ACTIVE = 2'd0,
        RG_FRONT  = 2'd1,
        RG_SYNC   = 2'd2,
        RG_BACK   = 2'd3
    } dtg_region_e;

    // Level control of one strobe.
    typedef struct packed {
        logic polarity;
        logic enable;
    } dtg_ctl_t;

endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
    import dtg_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [CW-1:0] act_end,
    input  logic [CW-1:0] front_end,
    input  logic [CW-1:0] sync_end,
    input  logic [CW-1:0] total,
    output logic [CW-1:0] pos,
    output dtg_region_e   region,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] pos;
    } axis_st_t;

    axis_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        last = (st_q.pos == (total - ONE));
        if (rst) begin
            st_d.pos = '0;
        end else if (adv) begin
            st_d.pos = last ? '0 : (st_q.pos + ONE);
        end

        if (st_q.pos < act_end) begin
            region = RG_ACTIVE;
        end else if (st_q.pos < front_end) begin
            region = RG_FRONT;
        end else if (st_q.pos < sync_end) begin
            region = RG_SYNC;
        end else begin
            region = RG_BACK;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pos = st_q.pos;

    // R1: the position returns to the origin after the last step of a span
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (adv && last) |=> (pos == '0));

    // R1: the position never leaves the programmed span
    p_range_r1: assert property (@(posedge clk) disable iff (rst)
        (pos < total));

    // R2: without an advance request the position holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos));

endmodule

// File: rtl/dtg_edge_stage.sv
module dtg_edge_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         edge_sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic         sel;
        logic [W-1:0] val;
    } launch_t;

    launch_t stage_d, rise_q, fall_q;

    always_comb begin
        stage_d.sel = edge_sel;
        stage_d.val = din;
    end

    always_ff @(posedge clk) begin
        rise_q <= stage_d;
    end

    always_ff @(negedge clk) begin
        fall_q <= stage_d;
    end

    // sel = 1 launches on the rising edge, sel = 0 on the falling edge
    assign dout = fall_q.sel ? rise_q.val : fall_q.val;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import dtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] cfg_h_active,
    input  logic [HW-1:0] cfg_h_front,
    input  logic [HW-1:0] cfg_h_sync,
    input  logic [HW-1:0] cfg_h_back,
    input  logic [VW-1:0] cfg_v_active,
    input  logic [VW-1:0] cfg_v_front,
    input  logic [VW-1:0] cfg_v_sync,
    input  logic [VW-1:0] cfg_v_back,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic          cfg_de_pol,
    input  logic          cfg_hs_en,
    input  logic          cfg_vs_en,
    input  logic          cfg_de_en,
    input  logic          cfg_data_edge,
    input  logic          cfg_sync_edge_own,
    input  logic          cfg_sync_edge,
    input  logic          cfg_dscan,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [HW-1:0] px_x,
    output logic [VW-1:0] px_y
);

    localparam int NSEG = 4;
    localparam int HCW  = HW + 2;
    localparam int VCW  = VW + 3;
    localparam int DW   = HW + VW + 1;

    typedef struct packed {
        logic [HCW-1:0] h_act_end;
        logic [HCW-1:0] h_front_end;
        logic [HCW-1:0] h_sync_end;
        logic [HCW-1:0] h_total;
        logic [VCW-1:0] v_act_end;
        logic [VCW-1:0] v_front_end;
        logic [VCW-1:0] v_sync_end;
        logic [VCW-1:0] v_total;
        dtg_ctl_t       hs;
        dtg_ctl_t       vs;
        dtg_ctl_t       de;
        logic           data_edge;
        logic           sync_edge;
        logic           dscan;
    } shadow_t;

    typedef struct packed {
        shadow_t sh;
    } gen_st_t;

    gen_st_t st_d, st_q;

    // ---------------- length clamping (R10) ----------------
    logic [HW-1:0]  h_raw [NSEG];
    logic [VW-1:0]  v_raw [NSEG];
    logic [HCW-1:0] h_len [NSEG];
    logic [VCW-1:0] v_len [NSEG];

    assign h_raw[0] = cfg_h_active;
    assign h_raw[1] = cfg_h_front;
    assign h_raw[2] = cfg_h_sync;
    assign h_raw[3] = cfg_h_back;
    assign v_raw[0] = cfg_v_active;
    assign v_raw[1] = cfg_v_front;
    assign v_raw[2] = cfg_v_sync;
    assign v_raw[3] = cfg_v_back;

    for (genvar i = 0; i < NSEG; i++) begin : g_clamp
        assign h_len[i] = (h_raw[i] == '0) ? HCW'(1) : HCW'(h_raw[i]);
        assign v_len[i] = (v_raw[i] == '0) ? VCW'(1) : VCW'(v_raw[i]);
    end

    // ---------------- settings to capture ----------------
    shadow_t        sh_new;
    logic [VCW-1:0] v_act_lines;

    always_comb begin
        v_act_lines        = cfg_dscan ? (v_len[0] << 1) : v_len[0];
        sh_new.h_act_end   = h_len[0];
        sh_new.h_front_end = h_len[0] + h_len[1];
        sh_new.h_sync_end  = h_len[0] + h_len[1] + h_len[2];
        sh_new.h_total     = h_len[0] + h_len[1] + h_len[2] + h_len[3];
        sh_new.v_act_end   = v_act_lines;
        sh_new.v_front_end = v_act_lines + v_len[1];
        sh_new.v_sync_end  = v_act_lines + v_len[1] + v_len[2];
        sh_new.v_total     = v_act_lines + v_len[1] + v_len[2] + v_len[3];
        sh_new.hs          = '{polarity: cfg_hs_pol, enable: cfg_hs_en};
        sh_new.vs          = '{polarity: cfg_vs_pol, enable: cfg_vs_en};
        sh_new.de          = '{polarity: cfg_de_pol, enable: cfg_de_en};
        sh_new.data_edge   = cfg_data_edge;
        sh_new.sync_edge   = cfg_sync_edge_own ? cfg_sync_edge : cfg_data_edge;
        sh_new.dscan       = cfg_dscan;
    end

    // ---------------- axis counters ----------------
    logic [HCW-1:0] h_pos;
    logic [VCW-1:0] v_pos;
    dtg_region_e    h_reg, v_reg;
    logic           h_last, v_last;
    logic           frame_end;

    dtg_axis #(.CW(HCW)) u_h_axis (
        .clk       (clk),
        .rst       (rst),
        .adv       (1'b1),
        .act_end   (st_q.sh.h_act_end),
        .front_end (st_q.sh.h_front_end),
        .sync_end  (st_q.sh.h_sync_end),
        .total     (st_q.sh.h_total),
        .pos       (h_pos),
        .region    (h_reg),
        .last      (h_last)
    );

    dtg_axis #(.CW(VCW)) u_v_axis (
        .clk       (clk),
        .rst       (rst),
        .adv       (h_last),
        .act_end   (st_q.sh.v_act_end),
        .front_end (st_q.sh.v_front_end),
        .sync_end  (st_q.sh.v_sync_end),
        .total     (st_q.sh.v_total),
        .pos       (v_pos),
        .region    (v_reg),
        .last      (v_last)
    );

    assign frame_end = h_last && v_last;

    // ---------------- settings register (R9, R11) ----------------
    always_comb begin
        st_d = st_q;
        if (rst || frame_end) begin
            st_d.sh = sh_new;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // ---------------- output levels ----------------
    logic          de_raw, hs_lvl, vs_lvl, de_lvl;
    logic [HW-1:0] x_val;
    logic [VW-1:0] y_val;

    always_comb begin
        de_raw = (h_reg == RG_ACTIVE) && (v_reg == RG_ACTIVE);
        hs_lvl = (st_q.sh.hs.enable && (h_reg == RG_SYNC)) ? st_q.sh.hs.polarity
                                                            : !st_q.sh.hs.polarity;
        vs_lvl = (st_q.sh.vs.enable && (v_reg == RG_SYNC)) ? st_q.sh.vs.polarity
                                                            : !st_q.sh.vs.polarity;
        de_lvl = (st_q.sh.de.enable && de_raw) ? st_q.sh.de.polarity
                                               : !st_q.sh.de.polarity;
        x_val  = de_raw ? h_pos[HW-1:0] : '0;
        if (!de_raw) begin
            y_val = '0;
        end else if (st_q.sh.dscan) begin
            y_val = v_pos[VW:1];
        end else begin
            y_val = v_pos[VW-1:0];
        end
    end

    // ---------------- launch stages (R5, R6) ----------------
    logic [1:0]    sync_out;
    logic [DW-1:0] data_out;

    dtg_edge_stage #(.W(2)) u_sync_stage (
        .clk      (clk),
        .edge_sel (st_q.sh.sync_edge),
        .din      ({hs_lvl, vs_lvl}),
        .dout     (sync_out)
    );

    dtg_edge_stage #(.W(DW)) u_data_stage (
        .clk      (clk),
        .edge_sel (st_q.sh.data_edge),
        .din      ({de_lvl, x_val, y_val}),
        .dout     (data_out)
    );

    assign hsync = sync_out[1];
    assign vsync = sync_out[0];
    assign de    = data_out[DW-1];
    assign px_x  = data_out[DW-2:VW];
    assign px_y  = data_out[VW-1:0];

    // ---------------- assertions ----------------
    // R9: captured settings change only at a frame boundary
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(st_q.sh));

    // R10: every region of both axes spans at least one step
    p_min_len_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q.sh.h_act_end != '0) && (st_q.sh.h_front_end > st_q.sh.h_act_end) &&
        (st_q.sh.h_sync_end > st_q.sh.h_front_end) && (st_q.sh.h_total > st_q.sh.h_sync_end) &&
        (st_q.sh.v_act_end != '0) && (st_q.sh.v_front_end > st_q.sh.v_act_end) &&
        (st_q.sh.v_sync_end > st_q.sh.v_front_end) && (st_q.sh.v_total > st_q.sh.v_sync_end));

    // R4: a disabled horizontal sync sits at its idle level at the pin
    p_unused_hs_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!st_q.sh.hs.enable) && !st_q.sh.hs.enable && $stable(st_q.sh.hs.polarity))
        |-> (hsync == !st_q.sh.hs.polarity));

    // R2: the row only moves at the end of a line
    p_row_step_r2: assert property (@(posedge clk) disable iff (rst)
        !h_last |=> $stable(v_pos));

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

    localparam int HW = 12;
    localparam int VW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] cfg_h_active, cfg_h_front, cfg_h_sync, cfg_h_back;
    logic [VW-1:0] cfg_v_active, cfg_v_front, cfg_v_sync, cfg_v_back;
    logic          cfg_hs_pol, cfg_vs_pol, cfg_de_pol;
    logic          cfg_hs_en, cfg_vs_en, cfg_de_en;
    logic          cfg_data_edge, cfg_sync_edge_own, cfg_sync_edge, cfg_dscan;
    logic          hsync, vsync, de;
    logic [HW-1:0] px_x;
    logic [VW-1:0] px_y;

    raster_timing_gen #(.HW(HW), .VW(VW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front),
        .cfg_h_sync(cfg_h_sync), .cfg_h_back(cfg_h_back),
        .cfg_v_active(cfg_v_active), .cfg_v_front(cfg_v_front),
        .cfg_v_sync(cfg_v_sync), .cfg_v_back(cfg_v_back),
        .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_de_pol(cfg_de_pol),
        .cfg_hs_en(cfg_hs_en), .cfg_vs_en(cfg_vs_en), .cfg_de_en(cfg_de_en),
        .cfg_data_edge(cfg_data_edge), .cfg_sync_edge_own(cfg_sync_edge_own),
        .cfg_sync_edge(cfg_sync_edge), .cfg_dscan(cfg_dscan),
        .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag      = "R11 reset";
    bit    finished = 0;

    typedef struct {
        logic hs, vs, de;
        int   x, y;
        logic sedge, dedge;
    } exp_t;

    // behavioural model state
    int   hp = 0, vp = 0;
    int   m_ha, m_hf, m_hs, m_hb, m_va, m_vf, m_vs, m_vb;
    logic m_hpol, m_vpol, m_dpol, m_hen, m_ven, m_den, m_dedge, m_sedge, m_ds;
    exp_t cur, prev;
    int   steps = 0;

    function automatic int at_least_one(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int vis_lines();
        return m_ds ? 2 * m_va : m_va;
    endfunction

    task automatic load_settings();
        m_ha = at_least_one(int'(cfg_h_active)); m_hf = at_least_one(int'(cfg_h_front));
        m_hs = at_least_one(int'(cfg_h_sync));   m_hb = at_least_one(int'(cfg_h_back));
        m_va = at_least_one(int'(cfg_v_active)); m_vf = at_least_one(int'(cfg_v_front));
        m_vs = at_least_one(int'(cfg_v_sync));   m_vb = at_least_one(int'(cfg_v_back));
        m_hpol = cfg_hs_pol; m_vpol = cfg_vs_pol; m_dpol = cfg_de_pol;
        m_hen = cfg_hs_en;   m_ven = cfg_vs_en;   m_den = cfg_de_en;
        m_dedge = cfg_data_edge;
        m_sedge = cfg_sync_edge_own ? cfg_sync_edge : cfg_data_edge;
        m_ds = cfg_dscan;
    endtask

    function automatic exp_t model_out();
        exp_t o;
        int   nv = vis_lines();
        bit   h_vis = (hp < m_ha);
        bit   v_vis = (vp < nv);
        bit   h_syn = (hp >= m_ha + m_hf) && (hp < m_ha + m_hf + m_hs);
        bit   v_syn = (vp >= nv + m_vf) && (vp < nv + m_vf + m_vs);
        bit   vis   = h_vis && v_vis;
        o.hs = (m_hen && h_syn) ? m_hpol : !m_hpol;
        o.vs = (m_ven && v_syn) ? m_vpol : !m_vpol;
        o.de = (m_den && vis) ? m_dpol : !m_dpol;
        o.x  = vis ? hp : 0;
        o.y  = vis ? (m_ds ? vp / 2 : vp) : 0;
        o.sedge = m_sedge;
        o.dedge = m_dedge;
        return o;
    endfunction

    task automatic model_step();
        if (rst) begin
            hp = 0; vp = 0;
            load_settings();
        end else if (hp == m_ha + m_hf + m_hs + m_hb - 1) begin
            hp = 0;
            if (vp == vis_lines() + m_vf + m_vs + m_vb - 1) begin
                vp = 0;
                load_settings();
            end else begin
                vp++;
            end
        end else begin
            hp++;
        end
        prev = cur;
        cur  = model_out();
        steps++;
    endtask

    task automatic compare(input exp_t e, input string phase);
        n_checks++;
        if (hsync !== e.hs || vsync !== e.vs || de !== e.de ||
            int'(px_x) !== e.x || int'(px_y) !== e.y) begin
            n_fails++;
            $display("FAIL %s [%s @%0t] hs/vs/de/x/y got %b %b %b %0d %0d expected %b %b %b %0d %0d",
                     tag, phase, $time, hsync, vsync, de, px_x, px_y,
                     e.hs, e.vs, e.de, e.x, e.y);
        end
    endtask

    // cycle-by-cycle comparison, both half cycles
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            model_step();
            #2;
            if (steps >= 3) compare(prev, "after rise");
            @(negedge clk);
            #2;
            e = prev;
            if (cur.sedge == 1'b0) begin e.hs = cur.hs; e.vs = cur.vs; end
            if (cur.dedge == 1'b0) begin e.de = cur.de; e.x = cur.x; e.y = cur.y; end
            if (steps >= 3) compare(e, "after fall");
        end
    end

    task automatic base_cfg();
        cfg_h_active = 12'd8; cfg_h_front = 12'd2; cfg_h_sync = 12'd3; cfg_h_back = 12'd4;
        cfg_v_active = 12'd4; cfg_v_front = 12'd1; cfg_v_sync = 12'd2; cfg_v_back = 12'd2;
        cfg_hs_pol = 1; cfg_vs_pol = 1; cfg_de_pol = 1;
        cfg_hs_en = 1;  cfg_vs_en = 1;  cfg_de_en = 1;
        cfg_data_edge = 1; cfg_sync_edge_own = 0; cfg_sync_edge = 0; cfg_dscan = 0;
    endtask

    // called at posedge + 3 after settings are written
    task automatic pulse_reset(input string t);
        rst = 1'b1;
        tag = t;
        repeat (2) @(posedge clk);
        #3;
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        base_cfg();
        repeat (3) @(posedge clk);
        #2;
        // R11: held in reset the generator sits on visible pixel (0,0)
        n_checks++;
        if (de !== 1'b1 || px_x !== '0 || px_y !== '0 || hsync !== 1'b0 || vsync !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 reset origin: de/x/y/hs/vs got %b %0d %0d %b %b expected 1 0 0 0 0",
                     de, px_x, px_y, hsync, vsync);
        end
        #1;
        rst = 1'b0;
        tag = "R1 R2 R8 base raster";
        run(400);

        cfg_hs_pol = 0; cfg_vs_pol = 0; cfg_de_pol = 0;
        pulse_reset("R3 active-low strobes");
        run(350);

        cfg_hs_pol = 1; cfg_vs_pol = 0; cfg_de_pol = 1;
        cfg_hs_en = 0; cfg_de_en = 0;
        pulse_reset("R4 unused hsync and data enable");
        run(320);

        base_cfg();
        cfg_vs_en = 0; cfg_vs_pol = 1; cfg_hs_pol = 0;
        pulse_reset("R4 unused vsync");
        run(320);

        base_cfg();
        cfg_data_edge = 0;
        pulse_reset("R5 R6 falling data edge, syncs follow");
        run(350);

        cfg_sync_edge_own = 1; cfg_sync_edge = 1;
        pulse_reset("R6 syncs rising, data falling");
        run(350);

        cfg_data_edge = 1; cfg_sync_edge_own = 1; cfg_sync_edge = 0;
        pulse_reset("R6 syncs falling, data rising");
        run(350);

        base_cfg();
        cfg_dscan = 1;
        pulse_reset("R7 line doubling");
        run(500);

        cfg_h_active = 0; cfg_h_front = 0; cfg_h_sync = 0; cfg_h_back = 0;
        cfg_v_active = 0; cfg_v_front = 0; cfg_v_sync = 0; cfg_v_back = 0;
        cfg_dscan = 0;
        pulse_reset("R10 all lengths zero");
        run(120);

        cfg_h_active = 3; cfg_v_active = 2; cfg_dscan = 1;
        pulse_reset("R10 R7 zero porches with doubling");
        run(150);

        base_cfg();
        pulse_reset("R9 mid-frame rewrite");
        run(60);
        cfg_h_active = 5; cfg_h_back = 1; cfg_v_front = 3; cfg_hs_pol = 0; cfg_data_edge = 0;
        run(500);

        base_cfg();
        run(200);
        pulse_reset("R11 reset in mid frame");
        run(200);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule